// File: doc/BRIEF.md
# Clock Frequency Check Monitor

This block watches a monitored clock against a reference clock and raises a fault when the monitored rate leaves a programmed band. While checking is on, the block counts monitored-clock edges over a window of a set number of reference-clock cycles. After each window it compares the count with an upper and a lower limit, then starts the next window at once. A count outside the band sets a sticky flag. Each flag can raise an interrupt request.

Software sets up the block through a small register interface that runs on the reference clock. It writes the window length and both limits while checking is stopped, then sets the enable bit. It can watch a running bit to see when measurement has actually begun. Flags are cleared by writing ones to them. The monitored-clock count crosses into the reference domain as a Gray-coded value through a synchroniser. Limits and window length are clamped on write to their useful ranges.

Top module: `clk_freq_monitor`

## Requirements
- R1: After reset the registers read as follows: control (address 0) 0, status (address 1) 0, interrupt enable (address 2) 0, window length (address 3) 80, upper limit (address 4) 0xFFFFFC, lower limit (address 5) 3. The interrupt output is low. Addresses 6 and 7 read 0.
- R2: Writing 1 to control bit 0 starts continuous checking. Status bit 2 (running) rises once measurement has begun. Writing 0 clears the running bit within two reference cycles and leaves the flags and the limit registers unchanged.
- R3: A window-length write below 80 stores 80. Each window lasts exactly the stored number of reference cycles.
- R4: A window count greater than the upper limit sets status bit 1 (too high). An upper-limit write above 0xFFFFFC stores 0xFFFFFC.
- R5: A window count smaller than the lower limit sets status bit 0 (too low). A lower-limit write below 3 stores 3.
- R6: A write to status with a 1 in bit 0 or bit 1 clears that flag, and a 0 leaves it unchanged. A flag stays set until it is cleared this way.
- R7: The interrupt output is high exactly when at least one of these holds: (too low AND enable bit 0 or bit 2) or (too high AND enable bit 1 or bit 3). Bits 0 and 1 are the synchronous enables and bits 2 and 3 are the asynchronous enables, each pair ordered low then high.
- R8: Writes to window length, upper limit and lower limit are ignored while the enable bit is set or measurement is still active.
- R9: A monitored rate whose window count lies between the limits sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register interface |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| mon_clk | input | 1 | Clock under test |
| mon_rst_n | input | 1 | Synchronous active-low reset, monitored domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted edge count or a window length off by a few cycles shows up as a wrong flag in status. This appears after the first complete window following enable, at most a window plus a few synchroniser cycles later, and only when the rate is near a limit. So rates are chosen with a clear margin on both sides of each limit. A state machine stuck in its active states shows as a running bit that does not clear two cycles after disable, and as configuration writes that are silently dropped. Bad interrupt gating shows on the irq pin in the cycle after the enable register is written.

// File: rtl/fcm_pkg.sv
`timescale 1ns/1ps
// Package: register address map, measurement states and status bit positions
// shared by the frequency monitor modules.
package fcm_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_STAT = 3'd1,
        ADDR_IEN  = 3'd2,
        ADDR_WIN  = 3'd3,
        ADDR_HIGH = 3'd4,
        ADDR_LOW  = 3'd5
    } fcm_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } fcm_state_e;

    localparam int FLAG_LOW  = 0;
    localparam int FLAG_HIGH = 1;

endpackage

// File: rtl/fcm_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchroniser for a bus.
// Assumes the bus changes at most one bit per source clock (Gray code or level).
module fcm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/fcm_mon_counter.sv
`timescale 1ns/1ps
// Monitored-clock edge counter. It counts while the synchronised run request
// is high and publishes a registered Gray code for the reference domain.
// Assumes run_req is a level from the reference domain.
module fcm_mon_counter #(
    parameter int CNT_W       = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic             mon_clk,
    input  logic             mon_rst_n,
    input  logic             run_req,
    output logic [CNT_W-1:0] gray_o
);

    logic             run_mon;
    logic [CNT_W-1:0] bin_q;

    fcm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_sync (
        .clk   (mon_clk),
        .rst_n (mon_rst_n),
        .d     (run_req),
        .q     (run_mon)
    );

    // Binary edge count, held when checking is stopped.
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n)   bin_q <= '0;
        else if (run_mon) bin_q <= bin_q + 1'b1;
    end

    // Registered Gray image so that only one bit changes per monitored edge.
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n) gray_o <= '0;
        else            gray_o <= bin_q ^ (bin_q >> 1);
    end

    AST_GRAY_ONE_STEP: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        $countones(gray_o ^ $past(gray_o)) <= 1); // R4

endmodule

// File: rtl/fcm_window.sv
`timescale 1ns/1ps
// Reference-domain measurement engine. It arms after enable, then repeats
// windows of win_len reference cycles. At the end of each window it takes the
// monitored count difference and compares it with both limits.
// Assumes win_len >= 2 and the limits are stable while active.
module fcm_window #(
    parameter int CNT_W       = 26,
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ARM_LEN     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CNT_W-1:0]  mon_gray,
    input  logic [DATA_W-1:0] win_len,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    output logic              running,
    output logic              active,
    output logic              evt_high,
    output logic              evt_low
);
    import fcm_pkg::*;

    localparam int ARM_W = $clog2(ARM_LEN + 1);

    fcm_state_e        state;
    logic [ARM_W-1:0]  arm_cnt;
    logic [DATA_W-1:0] win_cnt;
    logic [CNT_W-1:0]  gray_s;
    logic [CNT_W-1:0]  mon_bin_q;
    logic [CNT_W-1:0]  base_q;
    logic [CNT_W-1:0]  delta;

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    fcm_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mon_gray),
        .q     (gray_s)
    );

    // Convert the synchronised Gray count back to binary.
    always_ff @(posedge clk) begin
        if (!rst_n) mon_bin_q <= '0;
        else        mon_bin_q <= gray2bin(gray_s);
    end

    assign delta = mon_bin_q - base_q;

    // Sequence idle, arm and run, and evaluate each completed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            arm_cnt  <= '0;
            win_cnt  <= '0;
            base_q   <= '0;
            evt_high <= 1'b0;
            evt_low  <= 1'b0;
        end else begin
            evt_high <= 1'b0;
            evt_low  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (en) begin
                        state   <= ST_ARM;
                        arm_cnt <= '0;
                    end
                end
                ST_ARM: begin
                    if (!en) begin
                        state <= ST_IDLE;
                    end else if (arm_cnt == ARM_W'(ARM_LEN - 1)) begin
                        state   <= ST_RUN;
                        base_q  <= mon_bin_q;
                        win_cnt <= '0;
                    end else begin
                        arm_cnt <= arm_cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!en) begin
                        state <= ST_IDLE;
                    end else if (win_cnt == win_len - 1'b1) begin
                        win_cnt  <= '0;
                        base_q   <= mon_bin_q;
                        evt_high <= (delta > CNT_W'(hi_lim));
                        evt_low  <= (delta < CNT_W'(lo_lim));
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign running = (state == ST_RUN);
    assign active  = (state != ST_IDLE);

    AST_STOP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !running); // R2
    AST_EVT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_high || evt_low) |-> $past(running)); // R4
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (win_cnt < win_len)); // R3

endmodule

// File: rtl/fcm_regs.sv
`timescale 1ns/1ps
// Register file: control, sticky flags with write-one-to-clear, interrupt
// enables, and window and limit registers clamped on write and locked
// while measuring. Assumes one access per cycle on the reference clock.
module fcm_regs #(
    parameter int DATA_W  = 24,
    parameter int MIN_WIN = 80,
    parameter int LO_MIN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              running,
    input  logic              active,
    input  logic              evt_high,
    input  logic              evt_low,
    output logic              ctrl_en,
    output logic [DATA_W-1:0] win_len,
    output logic [DATA_W-1:0] hi_lim,
    output logic [DATA_W-1:0] lo_lim,
    output logic [1:0]        flags,
    output logic [3:0]        ien
);
    import fcm_pkg::*;

    localparam logic [DATA_W-1:0] WIN_FLOOR = DATA_W'(MIN_WIN);
    localparam logic [DATA_W-1:0] HI_CAP    = {DATA_W{1'b1}} - DATA_W'(3);
    localparam logic [DATA_W-1:0] LO_FLOOR  = DATA_W'(LO_MIN);

    logic lock;
    logic wr_stat;
    assign lock    = ctrl_en | active;
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);

    // Control enable and interrupt enables, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            ien     <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL) ctrl_en <= bus_wdata[0];
            if (bus_addr == ADDR_IEN)  ien     <= bus_wdata[3:0];
        end
    end

    // Window and limit registers, clamped, and ignored while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_len <= WIN_FLOOR;
            hi_lim  <= HI_CAP;
            lo_lim  <= LO_FLOOR;
        end else if (bus_wr && !lock) begin
            if (bus_addr == ADDR_WIN)
                win_len <= (bus_wdata < WIN_FLOOR) ? WIN_FLOOR : bus_wdata;
            if (bus_addr == ADDR_HIGH)
                hi_lim  <= (bus_wdata > HI_CAP) ? HI_CAP : bus_wdata;
            if (bus_addr == ADDR_LOW)
                lo_lim  <= (bus_wdata < LO_FLOOR) ? LO_FLOOR : bus_wdata;
        end
    end

    // Sticky flags: write-one-to-clear, a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags[FLAG_LOW]  <= (flags[FLAG_LOW]  & ~(wr_stat & bus_wdata[FLAG_LOW]))  | evt_low;
            flags[FLAG_HIGH] <= (flags[FLAG_HIGH] & ~(wr_stat & bus_wdata[FLAG_HIGH])) | evt_high;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl_en);
            ADDR_STAT: bus_rdata = DATA_W'({running, flags});
            ADDR_IEN:  bus_rdata = DATA_W'(ien);
            ADDR_WIN:  bus_rdata = win_len;
            ADDR_HIGH: bus_rdata = hi_lim;
            ADDR_LOW:  bus_rdata = lo_lim;
            default:   bus_rdata = '0;
        endcase
    end

    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lock) |=> ($stable(win_len) && $stable(hi_lim) && $stable(lo_lim))); // R8
    AST_W1C_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[FLAG_LOW] && !evt_low) |=> !flags[FLAG_LOW]); // R6
    AST_STICKY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_HIGH] && !(wr_stat && bus_wdata[FLAG_HIGH])) |=> flags[FLAG_HIGH]); // R6
    AST_WIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        win_len >= WIN_FLOOR); // R3
    AST_HI_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hi_lim <= HI_CAP); // R4
    AST_LO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        lo_lim >= LO_FLOOR); // R5

endmodule

// File: rtl/clk_freq_monitor.sv
`timescale 1ns/1ps
// Top of the clock frequency check monitor. It ties together the
// monitored-domain counter, the reference-domain window engine and the
// register file, and forms the interrupt request.
// Assumes the register interface runs on ref_clk.
module clk_freq_monitor #(
    parameter int DATA_W      = 24,
    parameter int CNT_W       = 26,
    parameter int SYNC_STAGES = 2,
    parameter int ARM_LEN     = 4,
    parameter int MIN_WIN     = 80,
    parameter int LO_MIN      = 3
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              mon_clk,
    input  logic              mon_rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              ctrl_en;
    logic              running;
    logic              active;
    logic              evt_high;
    logic              evt_low;
    logic [DATA_W-1:0] win_len;
    logic [DATA_W-1:0] hi_lim;
    logic [DATA_W-1:0] lo_lim;
    logic [1:0]        flags;
    logic [3:0]        ien;
    logic [CNT_W-1:0]  mon_gray;

    fcm_mon_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_mcnt (
        .mon_clk   (mon_clk),
        .mon_rst_n (mon_rst_n),
        .run_req   (ctrl_en),
        .gray_o    (mon_gray)
    );

    fcm_window #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
                 .ARM_LEN(ARM_LEN)) u_win (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .en       (ctrl_en),
        .mon_gray (mon_gray),
        .win_len  (win_len),
        .hi_lim   (hi_lim),
        .lo_lim   (lo_lim),
        .running  (running),
        .active   (active),
        .evt_high (evt_high),
        .evt_low  (evt_low)
    );

    fcm_regs #(.DATA_W(DATA_W), .MIN_WIN(MIN_WIN), .LO_MIN(LO_MIN)) u_regs (
        .clk       (ref_clk),
        .rst_n     (ref_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .running   (running),
        .active    (active),
        .evt_high  (evt_high),
        .evt_low   (evt_low),
        .ctrl_en   (ctrl_en),
        .win_len   (win_len),
        .hi_lim    (hi_lim),
        .lo_lim    (lo_lim),
        .flags     (flags),
        .ien       (ien)
    );

    // Request when any flag meets one of its two enables.
    assign irq = |({flags, flags} & ien);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        irq |-> (flags != 2'b00)); // R7

endmodule

// File: tb/sim_clk_freq_monitor.sv
`timescale 1ns/1ps
// Bench for the frequency monitor: directed corner cases plus seeded random
// monitored periods and limits, checked against bench-computed expectations.
module sim_clk_freq_monitor;

    localparam int REF_PERIOD = 10;
    localparam int WIN        = 200;

    logic        ref_clk = 1'b0;
    logic        mon_clk = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        mon_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [23:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic        irq;
    real         mon_half = 4.0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    clk_freq_monitor u0 (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .mon_clk   (mon_clk),
        .mon_rst_n (mon_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;
    always #(mon_half) mon_clk = ~mon_clk;

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge ref_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge ref_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] d);
        @(negedge ref_clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Expected status while running: running bit plus flags from the nominal count.
    function automatic logic [23:0] exp_status(input int per, input int hi, input int lo);
        real n;
        logic [23:0] s;
        n = (WIN * REF_PERIOD * 1.0) / per;
        s = 24'h4;
        if (n > hi) s[1] = 1'b1;
        if (n < lo) s[0] = 1'b1;
        return s;
    endfunction

    task automatic measure(input int per, input int hi, input int lo, output logic [23:0] st);
        wr(3'd0, 24'd0);
        wr(3'd1, 24'd3);
        wr(3'd3, 24'(WIN));
        wr(3'd4, 24'(hi));
        wr(3'd5, 24'(lo));
        mon_half = per / 2.0;
        wr(3'd0, 24'd1);
        repeat (3 * WIN + 50) @(negedge ref_clk);
        rd(3'd1, st);
    endtask

    initial begin : watchdog
        #(REF_PERIOD * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] v;
        int his[3];
        int los[3];
        his = '{260, 300, 350};
        los = '{190, 210, 230};
        void'($urandom(32'd4711));
        repeat (10) @(negedge ref_clk);
        ref_rst_n = 1'b1;
        mon_rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 24'd0);
        rd(3'd1, v); chk("R1 status", v, 24'd0);
        rd(3'd2, v); chk("R1 ien", v, 24'd0);
        rd(3'd3, v); chk("R1 window", v, 24'd80);
        rd(3'd4, v); chk("R1 high", v, 24'hFFFFFC);
        rd(3'd5, v); chk("R1 low", v, 24'd3);
        rd(3'd6, v); chk("R1 unmapped", v, 24'd0);
        chk("R1 irq", 24'(irq), 24'd0);

        // R3 R4 R5 clamping
        wr(3'd3, 24'd10);       rd(3'd3, v); chk("R3 window floor", v, 24'd80);
        wr(3'd4, 24'hFFFFFF);   rd(3'd4, v); chk("R4 high cap", v, 24'hFFFFFC);
        wr(3'd5, 24'd1);        rd(3'd5, v); chk("R5 low floor", v, 24'd3);

        // R9 nominal rate, R2 running and enable readback
        measure(8, 275, 230, v); chk("R9 nominal status", v, 24'h4);
        rd(3'd0, v); chk("R2 enable readback", v, 24'd1);

        // R8 config writes ignored while running
        wr(3'd3, 24'd500); rd(3'd3, v); chk("R8 window locked", v, 24'(WIN));
        wr(3'd4, 24'd999); rd(3'd4, v); chk("R8 high locked", v, 24'd275);

        // R4 fast clock
        measure(6, 275, 230, v); chk("R4 too high", v, 24'h6);

        // R7 interrupt masking with the high flag set
        wr(3'd2, 24'h0); chk("R7 masked", 24'(irq), 24'd0);
        wr(3'd2, 24'h1); chk("R7 low enable only", 24'(irq), 24'd0);
        wr(3'd2, 24'h8); chk("R7 high async enable", 24'(irq), 24'd1);
        wr(3'd2, 24'h2); chk("R7 high sync enable", 24'(irq), 24'd1);

        // R2 disable: running clears, flag and limits kept
        wr(3'd0, 24'd0);
        rd(3'd1, v); chk("R2 stop keeps flag", v, 24'h2);
        rd(3'd4, v); chk("R2 limit kept", v, 24'd275);

        // R6 write-one-to-clear
        wr(3'd1, 24'h0); rd(3'd1, v); chk("R6 write zero", v, 24'h2);
        wr(3'd1, 24'h1); rd(3'd1, v); chk("R6 other bit", v, 24'h2);
        chk("R7 irq still set", 24'(irq), 24'd1);
        wr(3'd1, 24'h2); rd(3'd1, v); chk("R6 cleared", v, 24'h0);
        chk("R7 irq cleared", 24'(irq), 24'd0);

        // R5 slow clock with async low enable
        measure(12, 275, 230, v); chk("R5 too low", v, 24'h5);
        wr(3'd2, 24'h4); chk("R7 low async enable", 24'(irq), 24'd1);
        wr(3'd2, 24'h0);

        // R4 R5 R9 random periods and limits
        for (int k = 0; k < 8; k++) begin
            int per;
            int hi;
            int lo;
            per = 4 + int'($urandom % 13);
            hi  = his[$urandom % 3];
            lo  = los[$urandom % 3];
            measure(per, hi, lo, v);
            chk("R4 R5 R9 random", v, exp_status(per, hi, lo));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule